// File: doc/BRIEF.md
# Two-Stage Instruction Fetch Front End

This block is the fetch side of a small 32-bit core with a two-stage pipeline. The first stage holds the fetch program counter and requests instruction words from memory. Every word the memory accepts moves into the second stage together with the address it came from. The execute unit decodes and runs that word. The execute unit may push back on the second stage, and it may redirect fetch to a new address when a branch or jump resolves.

The instruction port is a valid/ready-style handshake. `imem_req` acts as valid and `imem_ack` acts as ready. A fetch completes only in a cycle where both are high, and the memory returns the word in that same cycle. The request is raised only when the second stage can take the word, so back-pressure from execute stops fetch. The stage-two output is also a valid/ready pair: `ex_valid` offers the held instruction, and `ex_ready` low stalls it in place.

A redirect takes effect at the next clock edge. The fetch PC loads the target, stage two becomes a bubble for one cycle, and any word accepted in the same cycle is dropped. The cost of a taken branch is therefore one lost slot.

Top module: `fetch_frontend`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `imem_req` and `ex_valid` are low. The first requested address is 0x00000000.
- R2: After a cycle with `imem_req` and `imem_ack` high and no redirect, `imem_addr` is the previous address plus 4.
- R3: After a cycle with no accepted fetch, no redirect and no stall, `imem_addr` is unchanged and `ex_valid` is low. A bubble is inserted and no word is repeated.
- R4: After an accepted fetch without redirect, `ex_valid` is high. `ex_pc` equals the fetch address and `ex_instr` equals the returned word.
- R5: When `ex_valid` is high and `ex_ready` is low, `ex_pc`, `ex_instr` and `ex_valid` hold in the next cycle, and `imem_addr` holds.
- R6: After a cycle with `redirect` high, `imem_addr` equals the target that was presented and `ex_valid` is low.
- R7: A word accepted in the same cycle as a redirect never appears on the stage-two outputs.
- R8: `redirect` may be high only while `ex_valid` and `ex_ready` are both high.
- R9: `imem_req` is never high while stage two is stalled (`ex_valid` high, `ex_ready` low).
- R10: After a redirect, fetch continues sequentially from the target. The executed stream is the program order with every taken branch applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_req | output | 1 | Fetch request (valid) |
| imem_addr | output | 32 | Fetch address, equal to the fetch PC |
| imem_ack | input | 1 | Memory accepts the request this cycle (ready) |
| imem_rdata | input | 32 | Instruction word, valid when `imem_ack` is high |
| ex_valid | output | 1 | Stage two holds a live instruction |
| ex_pc | output | 32 | Address of the stage-two instruction |
| ex_instr | output | 32 | Stage-two instruction word |
| ex_ready | input | 1 | Execute consumes the stage-two instruction; low stalls it |
| redirect | input | 1 | Taken branch or jump from execute |
| redirect_target | input | 32 | New fetch address on redirect |

## Verification
The assertions assume that execute raises `redirect` only for an instruction it is consuming in that cycle, meaning `ex_valid` and `ex_ready` are both high. They also assume that `imem_rdata` is meaningful whenever `imem_ack` is high. The stimulus derives `redirect` and its target each cycle from the stage-two outputs and the `ex_ready` it has just driven, so that rule always holds. The memory model returns a word computed from the address, so a dropped or repeated word shows up as a mismatch. Acknowledges and stalls are varied at random across phases, so redirects land both with and without a concurrent fetch.

// File: rtl/fe_pkg.sv
package fe_pkg;
  localparam int unsigned FE_DEF_XLEN = 32;
  localparam int unsigned FE_DEF_ILEN = 32;
  localparam int unsigned FE_INSN_BYTES = 4;

  typedef enum logic [1:0] {
    PC_HOLD = 2'd0,
    PC_SEQ  = 2'd1,
    PC_JUMP = 2'd2
  } fe_pcsel_e;
endpackage

// File: rtl/fe_issue.sv
module fe_issue (
  input  logic              clk,
  input  logic              rst,
  input  logic              stage2_free,
  input  logic              imem_ack,
  input  logic              redirect,
  output logic              imem_req,
  output logic              fetch_take,
  output fe_pkg::fe_pcsel_e pcsel
);
  import fe_pkg::*;

  logic run_q;
  logic accept;

  // request stays low through reset and the first cycle after it
  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= 1'b1;
  end

  assign imem_req   = run_q && stage2_free;
  assign accept     = imem_req && imem_ack;
  // a word arriving with a redirect is wrong-path and dropped
  assign fetch_take = accept && !redirect;

  always_comb begin
    if (redirect)    pcsel = PC_JUMP;
    else if (accept) pcsel = PC_SEQ;
    else             pcsel = PC_HOLD;
  end

  assert_req_idle_after_reset_R1: assert property (
    @(posedge clk) disable iff (rst) $past(rst) |-> !imem_req);
endmodule

// File: rtl/fe_pc_reg.sv
module fe_pc_reg #(
  parameter int unsigned       XLEN     = fe_pkg::FE_DEF_XLEN,
  parameter logic [XLEN-1:0]   RESET_PC = '0,
  parameter int unsigned       STEP     = fe_pkg::FE_INSN_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  fe_pkg::fe_pcsel_e pcsel,
  input  logic [XLEN-1:0]   target,
  output logic [XLEN-1:0]   pc
);
  import fe_pkg::*;

  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  logic [XLEN-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= RESET_PC;
    end else begin
      unique case (pcsel)
        PC_JUMP: pc_q <= target;
        PC_SEQ:  pc_q <= pc_q + STEP_V;
        default: pc_q <= pc_q;
      endcase
    end
  end

  assign pc = pc_q;

  assert_jump_lands_R6: assert property (
    @(posedge clk) disable iff (rst) (pcsel == PC_JUMP) |=> (pc == $past(target)));
  assert_pc_hold_R3: assert property (
    @(posedge clk) disable iff (rst) (pcsel == PC_HOLD) |=> $stable(pc));
endmodule

// File: rtl/fe_stage2.sv
module fe_stage2 #(
  parameter int unsigned XLEN = fe_pkg::FE_DEF_XLEN,
  parameter int unsigned ILEN = fe_pkg::FE_DEF_ILEN
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            flush,
  input  logic            ex_ready,
  input  logic [XLEN-1:0] fetch_pc,
  input  logic [ILEN-1:0] fetch_insn,
  output logic            free,
  output logic            valid,
  output logic [XLEN-1:0] pc,
  output logic [ILEN-1:0] insn
);
  logic            valid_q;
  logic [XLEN-1:0] pc_q;
  logic [ILEN-1:0] insn_q;

  assign free = !valid_q || ex_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      pc_q    <= '0;
      insn_q  <= '0;
    end else if (flush) begin
      valid_q <= 1'b0;
    end else if (free) begin
      valid_q <= load;
      if (load) begin
        pc_q   <= fetch_pc;
        insn_q <= fetch_insn;
      end
    end
  end

  assign valid = valid_q;
  assign pc    = pc_q;
  assign insn  = insn_q;

  assert_stall_holds_R5: assert property (
    @(posedge clk) disable iff (rst)
      (valid && !ex_ready && !flush) |=> (valid && $stable(pc) && $stable(insn)));
  assert_flush_bubble_R6: assert property (
    @(posedge clk) disable iff (rst) flush |=> !valid);
endmodule

// File: rtl/fetch_frontend.sv
module fetch_frontend #(
  parameter int unsigned     XLEN     = fe_pkg::FE_DEF_XLEN,
  parameter int unsigned     ILEN     = fe_pkg::FE_DEF_ILEN,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  output logic            imem_req,
  output logic [XLEN-1:0] imem_addr,
  input  logic            imem_ack,
  input  logic [ILEN-1:0] imem_rdata,
  output logic            ex_valid,
  output logic [XLEN-1:0] ex_pc,
  output logic [ILEN-1:0] ex_instr,
  input  logic            ex_ready,
  input  logic            redirect,
  input  logic [XLEN-1:0] redirect_target
);
  import fe_pkg::*;

  logic      stage2_free;
  logic      fetch_take;
  fe_pcsel_e pcsel;

  fe_issue u_issue (
    .clk        (clk),
    .rst        (rst),
    .stage2_free(stage2_free),
    .imem_ack   (imem_ack),
    .redirect   (redirect),
    .imem_req   (imem_req),
    .fetch_take (fetch_take),
    .pcsel      (pcsel)
  );

  fe_pc_reg #(.XLEN(XLEN), .RESET_PC(RESET_PC), .STEP(FE_INSN_BYTES)) u_pc (
    .clk   (clk),
    .rst   (rst),
    .pcsel (pcsel),
    .target(redirect_target),
    .pc    (imem_addr)
  );

  fe_stage2 #(.XLEN(XLEN), .ILEN(ILEN)) u_s2 (
    .clk       (clk),
    .rst       (rst),
    .load      (fetch_take),
    .flush     (redirect),
    .ex_ready  (ex_ready),
    .fetch_pc  (imem_addr),
    .fetch_insn(imem_rdata),
    .free      (stage2_free),
    .valid     (ex_valid),
    .pc        (ex_pc),
    .insn      (ex_instr)
  );

  assert_no_req_in_stall_R9: assert property (
    @(posedge clk) disable iff (rst) (ex_valid && !ex_ready) |-> !imem_req);
  assert_redirect_legal_R8: assert property (
    @(posedge clk) disable iff (rst) redirect |-> (ex_valid && ex_ready));
  assert_seq_step_R2: assert property (
    @(posedge clk) disable iff (rst)
      (imem_req && imem_ack && !redirect) |=> (imem_addr == $past(imem_addr) + XLEN'(FE_INSN_BYTES)));
  assert_word_lands_R4: assert property (
    @(posedge clk) disable iff (rst)
      (imem_req && imem_ack && !redirect)
        |=> (ex_valid && ex_pc == $past(imem_addr) && ex_instr == $past(imem_rdata)));
  assert_wrong_path_dropped_R7: assert property (
    @(posedge clk) disable iff (rst) (imem_req && imem_ack && redirect) |=> !ex_valid);
endmodule

// File: tb/fetch_frontend_tb.sv
module fetch_frontend_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYCLES = 2400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imem_req;
  logic [31:0] imem_addr;
  logic        imem_ack = 1'b0;
  logic [31:0] imem_rdata;
  logic        ex_valid;
  logic [31:0] ex_pc;
  logic [31:0] ex_instr;
  logic        ex_ready = 1'b1;
  logic        redirect = 1'b0;
  logic [31:0] redirect_target = '0;

  int n_chk  = 0;
  int n_fail = 0;
  int n_retired = 0;
  logic [31:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_frontend u_dut (
    .clk(clk), .rst(rst),
    .imem_req(imem_req), .imem_addr(imem_addr),
    .imem_ack(imem_ack), .imem_rdata(imem_rdata),
    .ex_valid(ex_valid), .ex_pc(ex_pc), .ex_instr(ex_instr),
    .ex_ready(ex_ready), .redirect(redirect), .redirect_target(redirect_target)
  );

  function automatic logic [31:0] insn_of(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h1234ABCD;
  endfunction

  function automatic logic is_br(logic [31:0] a);
    return a[4:2] == 3'd5;
  endfunction

  function automatic logic [31:0] br_tgt(logic [31:0] a);
    return a + 32'h0000_0104;
  endfunction

  // memory model: word depends only on address
  assign imem_rdata = insn_of(imem_addr);

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: expected retirement stream in program order with branches taken (R10)
  task automatic push_program(input int n);
    logic [31:0] p;
    p = 32'h0;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(p);
      p = is_br(p) ? br_tgt(p) : p + 32'd4;
    end
  endtask

  // monitor: every consumed instruction must be next in program order (R4, R7, R10)
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (!rst && ex_valid && ex_ready) begin
        logic [31:0] e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hFFFF_FFFF;
        check(ex_pc == e, "R10 stream pc", ex_pc, e);
        check(ex_instr == insn_of(e), "R7 stream word", ex_instr, insn_of(e));
        n_retired++;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic p_req, p_ack, p_redir, p_valid, p_ready;
    logic [31:0] p_addr, p_tgt, p_pc, p_insn;
    push_program(3000);

    repeat (3) begin
      @(negedge clk);
      #1;
      check(!ex_valid, "R1 valid in reset", 32'(ex_valid), 0);
      check(!imem_req, "R1 req in reset", 32'(imem_req), 0);
    end
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(!imem_req, "R1 req first cycle", 32'(imem_req), 0);
    check(imem_addr == 32'h0, "R1 reset pc", imem_addr, 0);
    @(negedge clk);
    #1;
    check(imem_req, "R1 first request", 32'(imem_req), 1);
    check(imem_addr == 32'h0, "R1 first address", imem_addr, 0);
    p_req = imem_req; p_ack = 1'b0; p_redir = 1'b0; p_addr = imem_addr;
    p_tgt = '0; p_valid = ex_valid; p_ready = 1'b1; p_pc = ex_pc; p_insn = ex_instr;

    for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
      @(negedge clk);
      if (p_redir) begin
        check(imem_addr == p_tgt, "R6 target", imem_addr, p_tgt);
        check(!ex_valid, (p_req && p_ack) ? "R7 dropped word" : "R6 bubble", 32'(ex_valid), 0);
      end else if (p_req && p_ack) begin
        check(imem_addr == p_addr + 32'd4, "R2 pc step", imem_addr, p_addr + 32'd4);
        check(ex_valid && ex_pc == p_addr, "R4 stage pc", ex_pc, p_addr);
        check(ex_instr == insn_of(p_addr), "R4 stage word", ex_instr, insn_of(p_addr));
      end else begin
        check(imem_addr == p_addr, "R3 pc hold", imem_addr, p_addr);
        if (p_valid && !p_ready) begin
          check(ex_valid && ex_pc == p_pc, "R5 pc held", ex_pc, p_pc);
          check(ex_instr == p_insn, "R5 word held", ex_instr, p_insn);
        end else begin
          check(!ex_valid, "R3 bubble", 32'(ex_valid), 0);
        end
      end

      if (cyc < 300) begin
        imem_ack = 1'b1; ex_ready = 1'b1;
      end else if (cyc < 900) begin
        imem_ack = ($urandom % 2) == 0; ex_ready = 1'b1;
      end else begin
        imem_ack = ($urandom % 10) < 6; ex_ready = ($urandom % 10) < 7;
      end
      #1;
      redirect = ex_valid && ex_ready && is_br(ex_pc);
      redirect_target = br_tgt(ex_pc);
      #1;
      if (ex_valid && !ex_ready)
        check(!imem_req, "R9 no request in stall", 32'(imem_req), 0);
      p_req = imem_req; p_ack = imem_ack; p_redir = redirect; p_addr = imem_addr;
      p_tgt = redirect_target; p_valid = ex_valid; p_ready = ex_ready;
      p_pc = ex_pc; p_insn = ex_instr;
    end

    @(negedge clk);
    redirect = 1'b0;
    #4;
    check(n_retired > 300, "R2 forward progress", 32'(n_retired), 300);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule